// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block decides which control-store word a microcoded engine reads next. Each microinstruction carries a 9-bit base address and three sequencing bits. Two of these bits ask for a test of the negative flag or the zero flag from the previous ALU result. The third asks for a dispatch on the fetched opcode byte. The block merges these inputs into a 9-bit address. It holds that address in its own register, so the value is settled at the start of the next cycle, when the control store is read.

A conditional branch needs no adder and no second target field. If any requested flag test succeeds, the top address bit is forced to one. The two outcomes of a branch therefore sit exactly 256 words apart: the base address when not taken, and the base plus 256 when taken. An opcode dispatch ORs the 8-bit opcode into the low bits of the base address. A base of zero turns the opcode straight into the microcode entry point. Both mechanisms can act in the same cycle.

Top module: `useq_next_addr`

## Requirements
- R1: A synchronous active-high reset makes `mpc` read 0x000 after the next rising clock edge, whatever the other inputs are.
- R2: When `jam_n`, `jam_z` and `jump_op` are all 0, `mpc` equals the `addr_field` value sampled at the previous rising edge.
- R3: When `jam_n` and `flag_n` are both 1, bit 8 of `mpc` is 1 after the edge (for example, base 0x080 gives 0x180).
- R4: When `jam_z` and `flag_z` are both 1, bit 8 of `mpc` is 1 after the edge (for example, base 0x080 gives 0x180).
- R5: A flag at 1 whose test bit is 0 has no effect: `mpc` stays equal to the base address.
- R6: A test bit at 1 whose flag is 0 is a branch not taken: bit 8 of `mpc` equals bit 8 of the base (for example, base 0x080 gives 0x080).
- R7: When `jump_op` is 1, bits 7..0 of `mpc` equal bits 7..0 of `addr_field` ORed bitwise with `opcode`. When it is 0, `opcode` has no effect.
- R8: A taken flag test and an opcode dispatch in the same cycle both apply: bit 8 is forced to 1 and the low byte takes the OR with the opcode.
- R9: A base address whose bit 8 is already 1 keeps bit 8 at 1, whatever the flag tests give.
- R10: `mpc` is registered. It takes a new value at every rising edge, one cycle after its inputs, so inputs that change every cycle give one matching result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_field | input | 9 | Base next address from the microinstruction |
| jam_n | input | 1 | Request to test the negative flag |
| jam_z | input | 1 | Request to test the zero flag |
| jump_op | input | 1 | Request to OR the opcode into the low address byte |
| flag_n | input | 1 | Latched negative flag from the previous ALU result |
| flag_z | input | 1 | Latched zero flag from the previous ALU result |
| opcode | input | 8 | Fetched opcode byte |
| mpc | output | 9 | Registered next control-store address |

## Verification
Two functions can act in one cycle: a taken flag test and an opcode dispatch. They write separate parts of the address, and the bench sets both request bits together with a true flag to provoke the case. The expected value is then built from the requirements, with bit 8 forced high and the low byte ORed with the opcode. A stream of distinct input patterns is driven on every cycle, so that a result slipping by one cycle is also caught.

// File: rtl/useq_pkg.sv
package useq_pkg;
  // Default control-store address width; the opcode is one bit narrower.
  localparam int unsigned DEF_ADDR_W = 9;
  // Number of independent flag tests the sequencer supports.
  localparam int unsigned NUM_FLAG_TESTS = 2;

  typedef struct packed {
    logic test_n;
    logic test_z;
  } flag_req_t;
endpackage

// File: rtl/useq_jam_eval.sv
module useq_jam_eval #(
  parameter int unsigned NUM_TESTS = 2
) (
  input  logic [NUM_TESTS-1:0] test_req,
  input  logic [NUM_TESTS-1:0] flag_val,
  output logic                 taken
);
  logic [NUM_TESTS-1:0] hit;

  // One AND term per flag test; any successful test takes the branch.
  for (genvar g = 0; g < NUM_TESTS; g++) begin : g_test
    assign hit[g] = test_req[g] & flag_val[g];
  end

  assign taken = |hit;
endmodule

// File: rtl/useq_addr_merge.sv
module useq_addr_merge #(
  parameter int unsigned ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              taken,
  input  logic              jump_op,
  input  logic [ADDR_W-2:0] opcode,
  output logic [ADDR_W-1:0] next_addr
);
  localparam int unsigned HI = ADDR_W - 1;

  logic [HI-1:0] low_mask;

  always_comb begin
    low_mask  = jump_op ? opcode : '0;
    next_addr = {base_addr[HI] | taken, base_addr[HI-1:0] | low_mask};
  end
endmodule

// File: rtl/useq_mpc_reg.sv
module useq_mpc_reg #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_field,
  input  logic              jam_n,
  input  logic              jam_z,
  input  logic              jump_op,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic [ADDR_W-2:0] opcode,
  output logic [ADDR_W-1:0] mpc
);
  localparam int unsigned HI = ADDR_W - 1;

  flag_req_t                 req;
  logic [NUM_FLAG_TESTS-1:0] req_vec;
  logic [NUM_FLAG_TESTS-1:0] flag_vec;
  logic                      taken;
  logic [ADDR_W-1:0]         next_addr;

  assign req      = '{test_n: jam_n, test_z: jam_z};
  assign req_vec  = req;
  assign flag_vec = {flag_n, flag_z};

  useq_jam_eval #(.NUM_TESTS(NUM_FLAG_TESTS)) u_jam (
    .test_req (req_vec),
    .flag_val (flag_vec),
    .taken    (taken)
  );

  useq_addr_merge #(.ADDR_W(ADDR_W)) u_merge (
    .base_addr (addr_field),
    .taken     (taken),
    .jump_op   (jump_op),
    .opcode    (opcode),
    .next_addr (next_addr)
  );

  useq_mpc_reg #(.W(ADDR_W)) u_mpc (
    .clk (clk),
    .rst (rst),
    .d   (next_addr),
    .q   (mpc)
  );

  // Assertions on the port-level behaviour.
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_ZERO: assert (mpc == '0); // R1
    end
  end

  AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (rst)
    (!jam_n && !jam_z && !jump_op) |=> (mpc == $past(addr_field))); // R2
  AST_TAKEN_N: assert property (@(posedge clk) disable iff (rst)
    (jam_n && flag_n) |=> mpc[HI]); // R3
  AST_TAKEN_Z: assert property (@(posedge clk) disable iff (rst)
    (jam_z && flag_z) |=> mpc[HI]); // R4
  AST_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!(jam_n && flag_n) && !(jam_z && flag_z)) |=> (mpc[HI] == $past(addr_field[HI]))); // R6
  AST_DISPATCH_LOW: assert property (@(posedge clk) disable iff (rst)
    jump_op |=> (mpc[HI-1:0] == ($past(addr_field[HI-1:0]) | $past(opcode)))); // R7
  AST_NO_DISPATCH_LOW: assert property (@(posedge clk) disable iff (rst)
    !jump_op |=> (mpc[HI-1:0] == $past(addr_field[HI-1:0]))); // R7
  AST_HIGH_KEPT: assert property (@(posedge clk) disable iff (rst)
    addr_field[HI] |=> mpc[HI]); // R9
endmodule

// File: tb/useq_next_addr_tb.sv
module useq_next_addr_tb;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned WATCHDOG_CYC = 5000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr_field = '0;
  logic              jam_n = 1'b0, jam_z = 1'b0, jump_op = 1'b0;
  logic              flag_n = 1'b0, flag_z = 1'b0;
  logic [ADDR_W-2:0] opcode = '0;
  logic [ADDR_W-1:0] mpc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [ADDR_W-1:0] exp_q[$];
  string             tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  useq_next_addr #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .addr_field(addr_field), .jam_n(jam_n), .jam_z(jam_z),
    .jump_op(jump_op), .flag_n(flag_n), .flag_z(flag_z), .opcode(opcode), .mpc(mpc)
  );

  task automatic check(input string tag, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: mpc actual 0x%03h expected 0x%03h", tag, act, exp);
    end
  endtask

  // Driver: apply one input set at the falling edge and queue its expected result.
  task automatic drive(input string tag, input logic r, input logic [ADDR_W-1:0] a,
                       input logic jn, input logic jz, input logic jo,
                       input logic fn, input logic fz, input logic [ADDR_W-2:0] op);
    logic [ADDR_W-1:0] e;
    @(negedge clk);
    rst = r; addr_field = a; jam_n = jn; jam_z = jz; jump_op = jo;
    flag_n = fn; flag_z = fz; opcode = op;
    e[ADDR_W-1]   = a[ADDR_W-1] | (jn & fn) | (jz & fz);
    e[ADDR_W-2:0] = a[ADDR_W-2:0] | (jo ? op : '0);
    if (r) e = '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: shortly after each rising edge, compare against the oldest queued item.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      check(tag_q.pop_front(), mpc, exp_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", mpc, '0);
    drive("R2 plain 0x05a", 1'b0, 9'h05a, 0, 0, 0, 1, 1, 8'hff);
    drive("R2 plain 0x1c3", 1'b0, 9'h1c3, 0, 0, 0, 0, 0, 8'h00);
    drive("R3 N taken",     1'b0, 9'h080, 1, 0, 0, 1, 0, 8'h00);
    drive("R4 Z taken",     1'b0, 9'h080, 0, 1, 0, 0, 1, 8'h00);
    drive("R5 flags no test", 1'b0, 9'h045, 0, 0, 0, 1, 1, 8'h00);
    drive("R6 N not taken", 1'b0, 9'h080, 1, 0, 0, 0, 1, 8'h00);
    drive("R6 Z not taken", 1'b0, 9'h080, 0, 1, 0, 1, 0, 8'h00);
    drive("R7 dispatch base 0", 1'b0, 9'h000, 0, 0, 1, 0, 0, 8'h5c);
    drive("R7 dispatch OR", 1'b0, 9'h010, 0, 0, 1, 0, 0, 8'h03);
    drive("R7 opcode ignored", 1'b0, 9'h021, 0, 0, 0, 0, 0, 8'hc4);
    drive("R8 dispatch+jam",  1'b0, 9'h000, 0, 1, 1, 0, 1, 8'h60);
    drive("R8 dispatch+jamN", 1'b0, 9'h008, 1, 0, 1, 1, 0, 8'h81);
    drive("R9 high kept",   1'b0, 9'h1ab, 1, 1, 0, 0, 0, 8'h00);
    drive("R1 reset mid",   1'b1, 9'h1ff, 1, 1, 1, 1, 1, 8'hff);
    for (int i = 0; i < 24; i++) begin
      drive("R10 back-to-back", 1'b0, 9'((i * 37 + 5) % 512), i[0], i[1], i[2],
            i[3], i[1] ^ i[2], 8'((i * 53) % 256));
    end
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule